// File: doc/BRIEF.md
# Banked Data Memory with Pointer Redirection

This block stores the data space of a small 8-bit controller and decodes its 8-bit addresses. A requester presents one access per handshake: an address, a write flag and write data. Writes finish silently. Reads return one byte on a separate response channel. Below address 40H sit a few special registers: two memory pointers, a bank selector and the accumulator. From 40H upward sit 192-byte storage banks. Banks 0, 2 and 3 hold general data. Bank 1 holds the pixel bytes for a display.

Two addresses hold no storage: 00H and 02H. An access to 00H is carried out at the address held in pointer 0, and that access always lands in bank 0. An access to 02H is carried out at the address held in pointer 1, in the bank that the bank selector names. Direct accesses at 40H or above always use bank 0. So pointer 1 is the only way to reach banks 1, 2 and 3.

The request channel follows valid/ready rules. The block holds at most one unread response. While that response waits and the consumer holds `rsp_ready` low, `req_ready` stays low. Once a request is presented, the requester must hold it unchanged until it is accepted.

Top module: `dm_banked_mem`

## Requirements
- R1: Direct reads and writes at 40H to FFH reach bank 0 whatever the bank selector holds, and a written byte reads back unchanged.
- R2: Pointer 0 is at 01H and pointer 1 at 03H. Both are 8-bit and read back what was written. The accumulator at 05H behaves the same way. The bank selector at 04H keeps the low 5 bits of a write, and its bits 7:5 read as 0.
- R3: Addresses 06H to 3FH are unimplemented: a read returns 00H and a write changes nothing.
- R4: An access at 00H is carried out at the address in pointer 0, in bank 0, whatever the bank selector holds.
- R5: An access at 02H is carried out at the address in pointer 1, in the bank given by the bank selector: value 0, 2 or 3 picks that general bank, value 1 picks the display bank. A selector value of 4 or more reaches no storage, so a read returns 00H and a write is ignored.
- R6: An indirect access whose pointer holds 00H or 02H reads 00H, and a write through it changes nothing.
- R7: An indirect access whose pointer holds an address below 40H reaches the same special registers in every bank.
- R8: `req_ready` equals `!rsp_valid || rsp_ready`. Each accepted read raises `rsp_valid` on the next cycle. An accepted write produces no response. A response holds its data while `rsp_ready` is low.
- R9: After reset, both pointers, the bank selector and the accumulator read 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Direct address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data |

## Verification
The properties assume that the requester obeys the handshake. It holds address, flag and data steady until `req_ready` is seen, and it never depends on a response to a write. The bench drives every request from a single task, which changes inputs only half a cycle away from the capturing edge and waits for `req_ready` before it moves on. The bench lowers `rsp_ready` only in one dedicated stall phase, and raises it again before the next request, so no request can wait forever. Pointer contents always come from earlier writes through the request channel, so each indirect outcome follows from a known earlier state.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] IND0_ADDR = 8'h00;
  localparam logic [ADDR_W-1:0] PTR0_ADDR = 8'h01;
  localparam logic [ADDR_W-1:0] IND1_ADDR = 8'h02;
  localparam logic [ADDR_W-1:0] PTR1_ADDR = 8'h03;
  localparam logic [ADDR_W-1:0] BSEL_ADDR = 8'h04;
  localparam logic [ADDR_W-1:0] ACC_ADDR  = 8'h05;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_PTR0,
    TGT_PTR1,
    TGT_BSEL,
    TGT_ACC,
    TGT_RAM
  } tgt_e;
endpackage

// File: rtl/dm_addr_resolve.sv
module dm_addr_resolve
  import dm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BSEL_W    = 5,
  parameter logic [ADDR_W-1:0] GP_BASE = 8'h40,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int DEPTH  = (1 << ADDR_W) - int'(GP_BASE),
  localparam int OFS_W  = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ptr0,
  input  logic [ADDR_W-1:0] ptr1,
  input  logic [BSEL_W-1:0] bsel,
  output tgt_e              tgt,
  output logic [BANK_W-1:0] bank,
  output logic [OFS_W-1:0]  ofs
);
  logic [ADDR_W-1:0] eff;
  logic              bank_ok;

  always_comb begin
    eff     = addr;
    bank    = '0;
    bank_ok = 1'b1;
    if (addr == IND0_ADDR) begin
      eff = ptr0;
    end else if (addr == IND1_ADDR) begin
      eff     = ptr1;
      bank    = bsel[BANK_W-1:0];
      bank_ok = (bsel < BSEL_W'(NUM_BANKS));
    end
  end

  always_comb begin
    ofs = OFS_W'(eff - GP_BASE);
    tgt = TGT_NONE;
    if (eff >= GP_BASE) begin
      tgt = bank_ok ? TGT_RAM : TGT_NONE;
    end else begin
      unique case (eff)
        PTR0_ADDR: tgt = TGT_PTR0;
        PTR1_ADDR: tgt = TGT_PTR1;
        BSEL_ADDR: tgt = TGT_BSEL;
        ACC_ADDR:  tgt = TGT_ACC;
        default:   tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dm_bank_array.sv
module dm_bank_array
  import dm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 192,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int OFS_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (bank == BANK_W'(b))) mem[ofs] <= wdata;
    end
    assign bank_rd[b] = mem[ofs];
  end

  assign rdata = bank_rd[bank];
endmodule

// File: rtl/dm_special_regs.sv
module dm_special_regs
  import dm_pkg::*;
#(
  parameter int BSEL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  tgt_e              tgt,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] ptr0,
  output logic [ADDR_W-1:0] ptr1,
  output logic [BSEL_W-1:0] bsel,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr0 <= '0;
      ptr1 <= '0;
      bsel <= '0;
      acc  <= '0;
    end else if (we) begin
      unique case (tgt)
        TGT_PTR0: ptr0 <= ADDR_W'(wdata);
        TGT_PTR1: ptr1 <= ADDR_W'(wdata);
        TGT_BSEL: bsel <= wdata[BSEL_W-1:0];
        TGT_ACC:  acc  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (tgt)
      TGT_PTR0: rdata = DATA_W'(ptr0);
      TGT_PTR1: rdata = DATA_W'(ptr1);
      TGT_BSEL: rdata = DATA_W'(bsel);
      TGT_ACC:  rdata = acc;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/dm_banked_mem.sv
module dm_banked_mem
  import dm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BSEL_W    = 5,
  parameter logic [ADDR_W-1:0] GP_BASE = 8'h40,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int DEPTH  = (1 << ADDR_W) - int'(GP_BASE),
  localparam int OFS_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  tgt_e              tgt;
  logic [BANK_W-1:0] bank;
  logic [OFS_W-1:0]  ofs;
  logic [ADDR_W-1:0] ptr0_q, ptr1_q;
  logic [BSEL_W-1:0] bsel_q;
  logic [DATA_W-1:0] ram_rd, sr_rd, rd_mux;
  logic              accept, wr_en;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_we;

  dm_addr_resolve #(
    .NUM_BANKS(NUM_BANKS), .BSEL_W(BSEL_W), .GP_BASE(GP_BASE)
  ) u_resolve (
    .addr(req_addr), .ptr0(ptr0_q), .ptr1(ptr1_q), .bsel(bsel_q),
    .tgt(tgt), .bank(bank), .ofs(ofs)
  );

  dm_bank_array #(
    .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH)
  ) u_banks (
    .clk(clk), .we(wr_en && (tgt == TGT_RAM)), .bank(bank), .ofs(ofs),
    .wdata(req_wdata), .rdata(ram_rd)
  );

  dm_special_regs #(
    .BSEL_W(BSEL_W)
  ) u_sregs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .tgt(tgt), .wdata(req_wdata),
    .ptr0(ptr0_q), .ptr1(ptr1_q), .bsel(bsel_q), .rdata(sr_rd)
  );

  assign rd_mux = (tgt == TGT_RAM) ? ram_rd : sr_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_we) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dm_banked_mem_chk.sv
module dm_banked_mem_chk
  import dm_pkg::*;
#(
  parameter logic [ADDR_W-1:0] GP_BASE = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [ADDR_W-1:0] ptr0,
  input logic [ADDR_W-1:0] ptr1
);
  logic rd_acc;
  assign rd_acc = req_valid && req_ready && !req_we;

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R8
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  // R8
  wr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_we |=> !rsp_valid);

  // R2
  bsel_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_addr == BSEL_ADDR |=> rsp_data[7:5] == 3'b000);

  // R3
  unimpl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_addr > ACC_ADDR && req_addr < GP_BASE |=> rsp_data == '0);

  // R6
  ind0_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_addr == IND0_ADDR && (ptr0 == IND0_ADDR || ptr0 == IND1_ADDR)
    |=> rsp_data == '0);

  // R6
  ind1_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_addr == IND1_ADDR && (ptr1 == IND0_ADDR || ptr1 == IND1_ADDR)
    |=> rsp_data == '0);
endmodule

bind dm_banked_mem dm_banked_mem_chk #(.GP_BASE(GP_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .ptr0(ptr0_q), .ptr1(ptr1_q)
);

// File: tb/dm_banked_mem_tb.sv
module dm_banked_mem_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_we = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_banked_mem dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit we, input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = data;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] data);
    issue(1'b1, addr, data);
  endtask

  task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    issue(1'b0, addr, 8'h00);
  endtask

  // monitor: a response is taken at the edge after a sample with valid and ready
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected response", rsp_data, 8'h00);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data == e, t, rsp_data, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(rsp_valid == 1'b0, "R9 rsp_valid after reset", {7'd0, rsp_valid}, 8'h00);
    // R9 reset values
    rd(8'h01, 8'h00, "R9 ptr0 reset");
    rd(8'h03, 8'h00, "R9 ptr1 reset");
    rd(8'h04, 8'h00, "R9 bsel reset");
    rd(8'h05, 8'h00, "R9 acc reset");
    // R2 special registers
    wr(8'h05, 8'hA5); rd(8'h05, 8'hA5, "R2 acc readback");
    wr(8'h04, 8'hFF); rd(8'h04, 8'h1F, "R2 bsel 5-bit");
    wr(8'h01, 8'hC3); rd(8'h01, 8'hC3, "R2 ptr0 readback");
    wr(8'h04, 8'h00);
    // R1 direct bank 0
    wr(8'h40, 8'h11); wr(8'hFF, 8'h22);
    rd(8'h40, 8'h11, "R1 low edge");
    rd(8'hFF, 8'h22, "R1 high edge");
    wr(8'h04, 8'h02);
    rd(8'h40, 8'h11, "R1 bsel ignored");
    // R3 unimplemented
    wr(8'h06, 8'h77); wr(8'h3F, 8'h88);
    rd(8'h06, 8'h00, "R3 read 06");
    rd(8'h3F, 8'h00, "R3 read 3F");
    // R4 pointer 0
    wr(8'h01, 8'h50); wr(8'h00, 8'h33);
    rd(8'h50, 8'h33, "R4 write via ptr0");
    wr(8'h04, 8'h03);
    rd(8'h00, 8'h33, "R4 ptr0 ignores bsel");
    // R5 pointer 1
    wr(8'h04, 8'h02); wr(8'h03, 8'h50); wr(8'h02, 8'h44);
    rd(8'h50, 8'h33, "R5 bank0 untouched");
    rd(8'h02, 8'h44, "R5 bank2");
    wr(8'h04, 8'h03); wr(8'h02, 8'h55);
    rd(8'h02, 8'h55, "R5 bank3");
    wr(8'h04, 8'h02);
    rd(8'h02, 8'h44, "R5 bank2 kept");
    wr(8'h04, 8'h01); wr(8'h02, 8'h66);
    rd(8'h02, 8'h66, "R5 display bank");
    wr(8'h04, 8'h00);
    rd(8'h02, 8'h33, "R5 bank0 via ptr1");
    wr(8'h04, 8'h05); wr(8'h02, 8'h99);
    rd(8'h02, 8'h00, "R5 bsel 5 reads zero");
    wr(8'h04, 8'h02);
    rd(8'h02, 8'h44, "R5 bsel 5 write ignored");
    // R6 self-pointing
    wr(8'h01, 8'h00);
    rd(8'h00, 8'h00, "R6 ptr0 at 00");
    wr(8'h00, 8'hEE);
    rd(8'h01, 8'h00, "R6 ptr0 unchanged");
    wr(8'h01, 8'h02); wr(8'h00, 8'hEE);
    rd(8'h00, 8'h00, "R6 ptr0 at 02");
    rd(8'h03, 8'h50, "R6 ptr1 unchanged");
    wr(8'h03, 8'h02); wr(8'h02, 8'hEE);
    rd(8'h03, 8'h02, "R6 ptr1 at 02 write");
    rd(8'h02, 8'h00, "R6 ptr1 at 02 read");
    // R7 special registers through pointers
    wr(8'h04, 8'h03); wr(8'h03, 8'h05);
    rd(8'h02, 8'hA5, "R7 acc via ptr1 bank3");
    wr(8'h02, 8'h5A);
    rd(8'h05, 8'h5A, "R7 acc written via ptr1");
    wr(8'h01, 8'h04);
    rd(8'h00, 8'h03, "R7 bsel via ptr0");
    // R8 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    issue(1'b0, 8'h05, 8'h00);
    repeat (3) @(negedge clk);
    #1;
    check(rsp_valid == 1'b1, "R8 held valid", {7'd0, rsp_valid}, 8'h01);
    check(rsp_data == 8'h5A, "R8 held data", rsp_data, 8'h5A);
    check(req_ready == 1'b0, "R8 ready low", {7'd0, req_ready}, 8'h00);
    exp_q.push_back(8'h5A); tag_q.push_back("R8 released data");
    @(negedge clk); rsp_ready = 1'b1;
    @(negedge clk);
    rd(8'h40, 8'h11, "R8 next read");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all responses", 8'(exp_q.size()), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule